// File: doc/BRIEF.md
# Aliased Floating-Point Register File

This block holds the floating-point operand storage of a processor core. The storage is one array of 64 words of 32 bits. Software can name the same bits as single-precision (32-bit), double-precision (64-bit) or quad-precision (128-bit) registers, and the three views overlap. Singles reach only the lower half of the array. Doubles and quads reach the whole array. A single covers one word, a double covers two adjacent words and a quad covers four adjacent words, with the most significant word at the lowest index.

The block has two combinational read ports and one write port. Each port takes a 2-bit precision code and a 5-bit register number. The precision codes are 0 for single, 1 for double, 2 for quad, and 3 is reserved. For double and quad, the register number is folded so that bit 0 picks the upper bank: the double index is `{num[0], num[4:1]}`. A quad register is legal only when that double index is even, which means `num[1]` must be 0. An illegal number or the reserved code raises a per-port flag. An illegal write changes nothing.

Data on the ports is right-aligned in a 128-bit bus. The bits above the width of the chosen precision are zero. Storage contents are undefined after reset.

Top module: `aliased_fp_regfile`

## Requirements
- R1: Single register s (0..31) is storage word s. Singles 2k and 2k+1 are, in that order, the upper and lower 32 bits of double k, so no single reaches words 32..63.
- R2: With precision 1, number f selects double d = {f[0], f[4:1]}, which covers words 2d (bits 63:32) and 2d+1 (bits 31:0).
- R3: With precision 2 and f[1] = 0, the quad covers doubles d and d+1 (d = {f[0], f[4:1]}), that is words 2d..2d+3, with word 2d in bits 127:96.
- R4: A quad access with f[1] = 1 raises that port's illegal flag, and the read data is all zero.
- R5: A write that is illegal for its precision raises wr_illegal while wr_en is high and leaves every storage word unchanged.
- R6: Precision code 3 is illegal for every number on every port: read data is zero, the flag is raised, and a write is dropped.
- R7: A legal write changes only the words its register covers; all other words, including partners in the same double or quad, keep their values.
- R8: Reads are combinational from storage. A write is not visible in the cycle it is presented, and it is visible on the read ports from the next cycle.
- R9: A write presented while rst is high is dropped.
- R10: A single read drives bits 127:32 to zero, and a double read drives bits 127:64 to zero.
- R11: The two read ports decode and return data independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| ra_prec | input | 2 | Read port A precision (0 single, 1 double, 2 quad, 3 reserved) |
| ra_num | input | 5 | Read port A register number |
| ra_data | output | 128 | Read port A data, right-aligned |
| ra_illegal | output | 1 | Read port A illegal-register flag |
| rb_prec | input | 2 | Read port B precision |
| rb_num | input | 5 | Read port B register number |
| rb_data | output | 128 | Read port B data, right-aligned |
| rb_illegal | output | 1 | Read port B illegal-register flag |
| wr_en | input | 1 | Write request |
| wr_prec | input | 2 | Write precision |
| wr_num | input | 5 | Write register number |
| wr_data | input | 128 | Write data, right-aligned |
| wr_illegal | output | 1 | Write request names an illegal register |

## Verification
The bound checker watches every cycle for these properties:
- an odd-pair quad number or the reserved code always raises the flag;
- a flagged read returns zero;
- the bits above the selected width are zero;
- a legal write reads back on the next cycle at the same precision and number.

Only the bench scenarios can show the aliasing itself, because that needs a model of the whole array. These scenarios cover:
- singles landing in the upper or lower half of the matching double;
- quads spanning two doubles;
- upper-bank doubles being out of reach for singles;
- partner words surviving narrow writes;
- illegal and in-reset writes leaving the whole array untouched.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    localparam int WORD_W  = 32;
    localparam int NUM_W   = 5;
    localparam int MAX_LN  = 4;
    localparam int DATA_W  = WORD_W * MAX_LN;
    localparam int N_DBL   = 1 << NUM_W;
    localparam int N_WORDS = 2 * N_DBL;
    localparam int WIDX_W  = $clog2(N_WORDS);
    localparam int CNT_W   = $clog2(MAX_LN) + 1;

    typedef enum logic [1:0] {
        PREC_SGL  = 2'd0,
        PREC_DBL  = 2'd1,
        PREC_QUAD = 2'd2,
        PREC_RSVD = 2'd3
    } prec_e;

    typedef struct packed {
        logic [WIDX_W-1:0] base;
        logic [CNT_W-1:0]  nwords;
        logic              illegal;
    } loc_t;

    // Fold a register number into a starting word and a word count.
    function automatic loc_t locate(input prec_e p, input logic [NUM_W-1:0] n);
        loc_t             l;
        logic [NUM_W-1:0] dnum;
        dnum      = {n[0], n[NUM_W-1:1]};
        l.base    = '0;
        l.nwords  = '0;
        l.illegal = 1'b0;
        unique case (p)
            PREC_SGL: begin
                l.base   = {1'b0, n};
                l.nwords = CNT_W'(1);
            end
            PREC_DBL: begin
                l.base   = {dnum, 1'b0};
                l.nwords = CNT_W'(2);
            end
            PREC_QUAD: begin
                l.base    = {dnum, 1'b0};
                l.nwords  = CNT_W'(4);
                l.illegal = n[1];
            end
            default: l.illegal = 1'b1;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/fprf_decode.sv
module fprf_decode
    import fprf_pkg::*;
(
    input  logic [1:0]       prec,
    input  logic [NUM_W-1:0] num,
    output loc_t             loc
);
    always_comb loc = locate(prec_e'(prec), num);
endmodule

// File: rtl/fprf_rdport.sv
module fprf_rdport
    import fprf_pkg::*;
(
    input  logic [WORD_W-1:0] words [N_WORDS],
    input  loc_t              loc,
    output logic [DATA_W-1:0] data,
    output logic              illegal
);
    logic [WORD_W-1:0] lane [MAX_LN];

    for (genvar k = 0; k < MAX_LN; k++) begin : g_lane
        logic [WIDX_W-1:0] idx;
        assign idx     = loc.base + WIDX_W'(k);
        assign lane[k] = words[idx];
    end

    always_comb begin
        data    = '0;
        illegal = loc.illegal;
        if (!loc.illegal) begin
            unique case (loc.nwords)
                CNT_W'(1): data = {{(DATA_W-WORD_W){1'b0}}, lane[0]};
                CNT_W'(2): data = {{(DATA_W-2*WORD_W){1'b0}}, lane[0], lane[1]};
                CNT_W'(4): data = {lane[0], lane[1], lane[2], lane[3]};
                default:   data = '0;
            endcase
        end
    end
endmodule

// File: rtl/fprf_store.sv
module fprf_store
    import fprf_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  loc_t              loc,
    input  logic [DATA_W-1:0] wdata,
    output logic [WORD_W-1:0] words [N_WORDS]
);
    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        logic [WIDX_W-1:0] off;
        logic [CNT_W-1:0]  slot;
        logic              hit;
        logic [WORD_W-1:0] wval;

        always_comb begin
            off  = WIDX_W'(i) - loc.base;
            hit  = we && (off < WIDX_W'(loc.nwords));
            slot = loc.nwords - CNT_W'(1) - CNT_W'(off[CNT_W-2:0]);
            unique case (slot[1:0])
                2'd0:    wval = wdata[0*WORD_W +: WORD_W];
                2'd1:    wval = wdata[1*WORD_W +: WORD_W];
                2'd2:    wval = wdata[2*WORD_W +: WORD_W];
                default: wval = wdata[3*WORD_W +: WORD_W];
            endcase
        end

        always_ff @(posedge clk) begin
            if (hit) words[i] <= wval;
        end
    end
endmodule

// File: rtl/aliased_fp_regfile.sv
module aliased_fp_regfile
    import fprf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ra_prec,
    input  logic [NUM_W-1:0]  ra_num,
    output logic [DATA_W-1:0] ra_data,
    output logic              ra_illegal,
    input  logic [1:0]        rb_prec,
    input  logic [NUM_W-1:0]  rb_num,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_illegal,
    input  logic              wr_en,
    input  logic [1:0]        wr_prec,
    input  logic [NUM_W-1:0]  wr_num,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_illegal
);
    logic [WORD_W-1:0] words [N_WORDS];
    loc_t              loc_a, loc_b, loc_w;
    logic              we;

    fprf_decode u_dec_a (.prec(ra_prec), .num(ra_num), .loc(loc_a));
    fprf_decode u_dec_b (.prec(rb_prec), .num(rb_num), .loc(loc_b));
    fprf_decode u_dec_w (.prec(wr_prec), .num(wr_num), .loc(loc_w));

    assign wr_illegal = wr_en && loc_w.illegal;
    assign we         = wr_en && !rst && !loc_w.illegal;

    fprf_store u_store (
        .clk   (clk),
        .we    (we),
        .loc   (loc_w),
        .wdata (wr_data),
        .words (words)
    );

    fprf_rdport u_rd_a (.words(words), .loc(loc_a), .data(ra_data), .illegal(ra_illegal));
    fprf_rdport u_rd_b (.words(words), .loc(loc_b), .data(rb_data), .illegal(rb_illegal));
endmodule

// File: rtl/fprf_chk.sv
module fprf_chk
    import fprf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        ra_prec,
    input logic [NUM_W-1:0]  ra_num,
    input logic [DATA_W-1:0] ra_data,
    input logic              ra_illegal,
    input logic [1:0]        rb_prec,
    input logic [NUM_W-1:0]  rb_num,
    input logic [DATA_W-1:0] rb_data,
    input logic              rb_illegal,
    input logic              wr_en,
    input logic [1:0]        wr_prec,
    input logic [NUM_W-1:0]  wr_num,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_illegal
);
    logic [DATA_W-1:0] wr_view;
    always_comb begin
        unique case (wr_prec)
            2'd0:    wr_view = {{(DATA_W-WORD_W){1'b0}}, wr_data[WORD_W-1:0]};
            2'd1:    wr_view = {{(DATA_W-2*WORD_W){1'b0}}, wr_data[2*WORD_W-1:0]};
            default: wr_view = wr_data;
        endcase
    end

    AST_QUAD_ODD_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ra_prec == 2'd2 && ra_num[1]) |-> ra_illegal); // R4
    AST_ILLEGAL_ZERO_A: assert property (@(posedge clk) disable iff (rst)
        ra_illegal |-> (ra_data == '0)); // R4
    AST_ILLEGAL_ZERO_B: assert property (@(posedge clk) disable iff (rst)
        rb_illegal |-> (rb_data == '0)); // R6
    AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_prec == 2'd3) |-> wr_illegal); // R6
    AST_SGL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ra_prec == 2'd0) |-> (ra_data[DATA_W-1:WORD_W] == '0)); // R10
    AST_DBL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rb_prec == 2'd1) |-> (rb_data[DATA_W-1:2*WORD_W] == '0)); // R10
    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_illegal) |=> ((ra_prec != $past(wr_prec)) ||
                                    (ra_num != $past(wr_num)) ||
                                    (ra_data == $past(wr_view)))); // R8
endmodule

bind aliased_fp_regfile fprf_chk u_chk (.*);

// File: tb/aliased_fp_regfile_tb.sv
`timescale 1ns/1ps
module aliased_fp_regfile_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   ra_prec = '0, rb_prec = '0, wr_prec = '0;
    logic [4:0]   ra_num = '0, rb_num = '0, wr_num = '0;
    logic [127:0] ra_data, rb_data, wr_data = '0;
    logic         ra_illegal, rb_illegal, wr_illegal;
    logic         wr_en = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    aliased_fp_regfile u_dut (.*);

    typedef struct {
        int           port;   // 0 = A, 1 = B, 2 = write flag
        logic [127:0] data;
        logic         ill;
        string        tag;
    } item_t;

    item_t       q[$];
    logic [31:0] model [64];

    function automatic int m_base(input logic [1:0] p, input logic [4:0] n);
        if (p == 2'd0) return int'(n);
        return 2 * int'({n[0], n[4:1]});
    endfunction

    function automatic int m_cnt(input logic [1:0] p);
        case (p)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic m_ill(input logic [1:0] p, input logic [4:0] n);
        return (p == 2'd3) || (p == 2'd2 && n[1]);
    endfunction

    function automatic logic [127:0] m_data(input logic [1:0] p, input logic [4:0] n);
        logic [127:0] r = '0;
        if (m_ill(p, n)) return '0;
        for (int k = 0; k < m_cnt(p); k++) r = (r << 32) | 128'(model[m_base(p, n) + k]);
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input int port, input logic [1:0] p, input logic [4:0] n, input string tag);
        item_t it;
        it.port = port;
        it.data = m_data(p, n);
        it.ill  = m_ill(p, n);
        it.tag  = tag;
        q.push_back(it);
    endtask

    // Monitor: compare queued expectations at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            case (it.port)
                0: begin
                    check({it.tag, " A data"}, ra_data, it.data);
                    check({it.tag, " A flag"}, 128'(ra_illegal), 128'(it.ill));
                end
                1: begin
                    check({it.tag, " B data"}, rb_data, it.data);
                    check({it.tag, " B flag"}, 128'(rb_illegal), 128'(it.ill));
                end
                default: check({it.tag, " wr flag"}, 128'(wr_illegal), 128'(it.ill));
            endcase
        end
    end

    task automatic do_read(input logic [1:0] pa, input logic [4:0] na,
                           input logic [1:0] pb, input logic [4:0] nb, input string tag);
        @(posedge clk); #1;
        ra_prec = pa; ra_num = na; rb_prec = pb; rb_num = nb;
        push(0, pa, na, tag);
        push(1, pb, nb, tag);
    endtask

    // Port A watches the target: old value during the write cycle, new value after it.
    task automatic do_write(input logic [1:0] p, input logic [4:0] n,
                            input logic [127:0] d, input string tag);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_prec = p; wr_num = n; wr_data = d;
        ra_prec = p; ra_num = n;
        push(0, p, n, {tag, " same-cycle"});
        push(2, p, n, tag);
        @(posedge clk);
        if (!m_ill(p, n) && !rst)
            for (int k = 0; k < m_cnt(p); k++)
                model[m_base(p, n) + k] = d[32*(m_cnt(p)-1-k) +: 32];
        #1;
        wr_en = 1'b0;
        push(0, p, n, {tag, " next-cycle"});
    endtask

    task automatic verify_all_doubles(input string tag);
        for (int i = 0; i < 32; i += 2)
            do_read(2'd1, 5'(i), 2'd1, 5'(i + 1), tag);
    endtask

    initial begin
        // Reset state: flags follow the decode even during reset.
        repeat (2) @(posedge clk);
        #1; ra_prec = 2'd0; ra_num = 5'd7; rb_prec = 2'd3; rb_num = 5'd0;
        @(negedge clk);
        check("reset R6 A flag single", 128'(ra_illegal), 128'(0));
        check("reset R6 B flag reserved", 128'(rb_illegal), 128'(1));
        @(posedge clk); #1; rst = 1'b0;

        // Fill the whole array through double writes.
        for (int i = 0; i < 32; i++)
            do_write(2'd1, 5'(i), {64'h0, 32'hD000_0000 | 32'(i), 32'hE000_0000 | 32'(i)}, "init R2 R8");

        // R1 and R2 on both ports at once (R11).
        for (int i = 0; i < 32; i++)
            do_read(2'd0, 5'(i), 2'd1, 5'(31 - i), "R1 R2 R11 read");

        // R3: every legal quad; R4: every odd-pair quad.
        for (int i = 0; i < 32; i++)
            do_read(2'd2, 5'(i), 2'd1, 5'(i), i[1] ? "R4 odd quad" : "R3 quad");

        // R10: narrow reads after a full-width write must stay zero-extended.
        do_write(2'd2, 5'd0, 128'hAAAA_0001_BBBB_0002_CCCC_0003_DDDD_0004, "R3 quad write");
        do_read(2'd0, 5'd0, 2'd1, 5'd0, "R10 zero-extend");
        do_read(2'd0, 5'd1, 2'd1, 5'd2, "R10 partner words");

        // R7: single write touches one word only.
        do_write(2'd0, 5'd5, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_1234_5678, "R7 single write");
        do_read(2'd0, 5'd4, 2'd1, 5'd4, "R7 neighbour");
        do_read(2'd0, 5'd5, 2'd2, 5'd4, "R7 quad view");

        // R7: upper-bank double write and its quad partner.
        do_write(2'd1, 5'd3, 128'h1111_2222_3333_4444_5555_6666_7777_8888, "R7 upper double");
        do_read(2'd2, 5'd1, 2'd1, 5'd1, "R7 upper quad");

        // R5: odd-pair quad write suppressed; R6: reserved write suppressed.
        do_write(2'd2, 5'd2, {4{32'h0BAD_F00D}}, "R5 illegal quad write");
        do_write(2'd3, 5'd9, {4{32'hDEAD_BEEF}}, "R6 reserved write");
        verify_all_doubles("R5 R6 array unchanged");

        // R9: write during reset dropped.
        @(posedge clk); #1; rst = 1'b1;
        do_write(2'd1, 5'd6, 128'h0000_0000_0000_0000_9999_9999_9999_9999, "R9 write in reset");
        @(posedge clk); #1; rst = 1'b0;
        do_read(2'd1, 5'd6, 2'd0, 5'd6, "R9 after reset");

        repeat (3) @(posedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule